// File: doc/BRIEF.md
# External interrupt priority arbiter

The block takes eight external interrupt channels, arranged as four pairs (A, B, C, D, each with an even member x0 and an odd member x1). It catches a rising edge on each channel in a pending latch, and from the enabled pending channels it picks one winner. It then raises a request toward the CPU only when that winner outranks the priority level the CPU is already running at. With the request it presents the winner's 3-bit level, its channel number and an 8-bit interrupt vector.

Software configures the block through a small register bus with two registers. The priority register gives each channel pair two programmable priority bits. A hardwired third bit, 0 for the even channel and 1 for the odd one, completes a 3-bit level on which 0 is the most urgent. The vector register supplies the upper vector nibble. Its low nibble holds the control bit that chooses whether channel A0 listens to its pin or to a watchdog end-of-count pulse. The CPU clears a pending latch with a single acknowledge strobe that carries the channel number.

Top module: `ext_irq_arbiter`

## Requirements
- R1: The priority register sits at bus address 0, reads back on `reg_rdata` while `reg_addr` is 0, resets to 8'hFF, and takes `reg_wdata` on a clock edge where `reg_wr` is high with address 0.
- R2: The vector register sits at bus address 1. Its bits 3:0 reset to 4'b0110. Its bits 7:4 are left alone by reset. A write replaces all eight bits. Addresses 2 and 3 read as zero.
- R3: Channel index is 0..7 for A0, A1, B0, B1, C0, C1, D0, D1. Channel i belongs to pair p = i/2, and its level is {prio[2p+1], prio[2p], i[0]}. Level 0 is the highest priority and level 7 the lowest. `irq_level` shows the winner's level.
- R4: Bit 1 of the vector register picks the source for channel 0: 1 takes `irq_pin[0]`, 0 takes `wdog_eoc`. The source not selected has no effect on `irq_pending[0]`.
- R5: A channel's pending bit on `irq_pending` becomes 1 at the clock edge where its selected input is 1 and was 0 at the previous edge. It does not set otherwise. Inputs held high from reset do not count as an edge.
- R6: An edge with `irq_ack` high clears the pending bit of channel `ack_chan` and leaves the others as they are. If a new rising edge on that channel arrives at the same clock edge, the bit stays set.
- R7: The winner is the enabled (`irq_en` bit 1) pending channel with the numerically lowest level. When levels are equal, the lowest channel index wins. A disabled channel never wins but stays pending.
- R8: `irq_req` is 1 exactly when some enabled channel is pending and the winner's level is strictly below `cur_level`.
- R9: When `irq_req` is 1, `irq_vector` equals {vector register bits 7:4, winner channel index, 1'b0} and `irq_chan` equals the winner channel index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_pin | input | 8 | External interrupt inputs, one per channel |
| wdog_eoc | input | 1 | Watchdog end-of-count, alternative source for channel 0 |
| irq_en | input | 8 | Per-channel enable for arbitration |
| cur_level | input | 3 | Level the CPU is currently serving |
| irq_ack | input | 1 | Acknowledge strobe |
| ack_chan | input | 3 | Channel being acknowledged |
| irq_pending | output | 8 | Pending latches |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_level | output | 3 | Level of the winning channel |
| irq_chan | output | 3 | Index of the winning channel |
| irq_vector | output | 8 | Interrupt vector for the winner |

## Verification
The assertions assume that `cur_level`, `irq_en`, `ack_chan` and the register bus stay stable across each rising clock edge. They check the vector's low nibble only, because the upper nibble has no reset value. The assertions also assume that a bus write to address 1 is what defines bits 7:4. The stimulus therefore changes inputs only just after a clock edge. It writes the vector register during the directed phase, before any check compares the vector's upper bits or reads address 1 in full.

// File: rtl/eia_pkg.sv
package eia_pkg;
    localparam int NCH = 8;
    localparam int CW  = $clog2(NCH);
    localparam int LW  = 3;
    localparam int DW  = 8;
    localparam int AW  = 2;
    localparam int NIB = DW / 2;

    localparam logic [DW-1:0]  PRIO_RST  = 8'hFF;
    localparam logic [NIB-1:0] VLO_RST   = 4'b0110;
    localparam int             SEL_BIT   = 1;
    localparam logic [AW-1:0]  ADDR_PRIO = 2'd0;
    localparam logic [AW-1:0]  ADDR_VEC  = 2'd1;

    typedef struct packed {
        logic [DW-1:0]  prio;
        logic [NIB-1:0] vlo;
    } cfg_t;

    typedef struct packed {
        logic [NCH-1:0] prev;
        logic [NCH-1:0] pend;
    } pend_t;

    function automatic logic [LW-1:0] chan_level(input logic [DW-1:0] prio,
                                                 input logic [CW-1:0] ch);
        return {prio[{ch[CW-1:1], 1'b1}], prio[{ch[CW-1:1], 1'b0}], ch[0]};
    endfunction
endpackage

// File: rtl/eia_regs.sv
module eia_regs
    import eia_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic [DW-1:0]  prio,
    output logic [NIB-1:0] vhi,
    output logic [NIB-1:0] vlo
);
    cfg_t           cfg_d, cfg_q;
    logic [NIB-1:0] vhi_d, vhi_q;

    always_comb begin
        cfg_d = cfg_q;
        vhi_d = vhi_q;
        if (wr) begin
            if (addr == ADDR_PRIO) begin
                cfg_d.prio = wdata;
            end
            if (addr == ADDR_VEC) begin
                cfg_d.vlo = wdata[NIB-1:0];
                vhi_d     = wdata[DW-1:NIB];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.prio <= PRIO_RST;
            cfg_q.vlo  <= VLO_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Upper vector nibble deliberately has no reset.
    always_ff @(posedge clk) begin
        vhi_q <= vhi_d;
    end

    always_comb begin
        case (addr)
            ADDR_PRIO: rdata = cfg_q.prio;
            ADDR_VEC:  rdata = {vhi_q, cfg_q.vlo};
            default:   rdata = '0;
        endcase
    end

    assign prio = cfg_q.prio;
    assign vhi  = vhi_q;
    assign vlo  = cfg_q.vlo;

    a_r1_prio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == ADDR_PRIO) |=> $stable(prio));

    a_r1_prio_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_PRIO) |=> prio == $past(wdata));

    a_r2_vec_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_VEC) |=> {vhi, vlo} == $past(wdata));
endmodule

// File: rtl/eia_pending.sv
module eia_pending
    import eia_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin,
    input  logic           wdog,
    input  logic           a0_from_pin,
    input  logic           ack,
    input  logic [CW-1:0]  ack_chan,
    output logic [NCH-1:0] pend
);
    pend_t          st_d, st_q;
    logic [NCH-1:0] src;
    logic [NCH-1:0] rise;
    logic [NCH-1:0] clr;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        if (g == 0) begin : g_sel
            assign src[g] = a0_from_pin ? pin[g] : wdog;
        end else begin : g_pin
            assign src[g] = pin[g];
        end
        assign clr[g] = ack && (ack_chan == CW'(g));

        a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !rise[g]) |=> !pend[g]);

        a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> pend[g]);

        a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend[g] && !rise[g]) |=> !pend[g]);
    end

    assign rise = src & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = src;
        st_d.pend = (st_q.pend & ~clr) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= '1;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/eia_arbiter.sv
module eia_arbiter
    import eia_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  prio,
    input  logic [NCH-1:0] pend,
    input  logic [NCH-1:0] en,
    input  logic [LW-1:0]  cur_level,
    output logic           req,
    output logic [LW-1:0]  win_level,
    output logic [CW-1:0]  win_chan
);
    logic [NCH-1:0] live;
    logic [LW-1:0]  lvl;
    logic           found;

    assign live = pend & en;

    // Strict compare keeps the lower index on equal levels.
    always_comb begin
        found     = 1'b0;
        win_level = '1;
        win_chan  = '0;
        lvl       = '0;
        for (int i = 0; i < NCH; i++) begin
            lvl = chan_level(prio, CW'(i));
            if (live[i] && (!found || lvl < win_level)) begin
                found     = 1'b1;
                win_level = lvl;
                win_chan  = CW'(i);
            end
        end
    end

    assign req = found && (win_level < cur_level);

    a_r7_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (pend[win_chan] && en[win_chan]));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (live == '0) |-> !req);

    a_r8_above_current: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (win_level < cur_level));
endmodule

// File: rtl/ext_irq_arbiter.sv
module ext_irq_arbiter
    import eia_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [1:0]     reg_addr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    input  logic [7:0]     irq_pin,
    input  logic           wdog_eoc,
    input  logic [7:0]     irq_en,
    input  logic [2:0]     cur_level,
    input  logic           irq_ack,
    input  logic [2:0]     ack_chan,
    output logic [7:0]     irq_pending,
    output logic           irq_req,
    output logic [2:0]     irq_level,
    output logic [2:0]     irq_chan,
    output logic [7:0]     irq_vector
);
    logic [DW-1:0]  prio;
    logic [NIB-1:0] vhi;
    logic [NIB-1:0] vlo;

    eia_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .prio  (prio),
        .vhi   (vhi),
        .vlo   (vlo)
    );

    eia_pending u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin         (irq_pin),
        .wdog        (wdog_eoc),
        .a0_from_pin (vlo[SEL_BIT]),
        .ack         (irq_ack),
        .ack_chan    (ack_chan),
        .pend        (irq_pending)
    );

    eia_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .prio      (prio),
        .pend      (irq_pending),
        .en        (irq_en),
        .cur_level (cur_level),
        .req       (irq_req),
        .win_level (irq_level),
        .win_chan  (irq_chan)
    );

    assign irq_vector = {vhi, irq_chan, 1'b0};

    a_r9_vector_low: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector[3:0] == {irq_chan, 1'b0}));

    a_r3_level_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level[0] == irq_chan[0]));
endmodule

// File: tb/ext_irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module ext_irq_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] irq_pin = '0;
    logic       wdog_eoc = 1'b0;
    logic [7:0] irq_en = '0;
    logic [2:0] cur_level = '0;
    logic       irq_ack = 1'b0;
    logic [2:0] ack_chan = '0;
    logic [7:0] irq_pending;
    logic       irq_req;
    logic [2:0] irq_level;
    logic [2:0] irq_chan;
    logic [7:0] irq_vector;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_prio;
    logic [3:0] m_vhi;
    logic [3:0] m_vlo;
    logic [7:0] m_prev;
    logic [7:0] m_pend;
    bit         vhi_known = 1'b0;

    always #2.5 clk = ~clk;

    ext_irq_arbiter dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_pin     (irq_pin),
        .wdog_eoc    (wdog_eoc),
        .irq_en      (irq_en),
        .cur_level   (cur_level),
        .irq_ack     (irq_ack),
        .ack_chan    (ack_chan),
        .irq_pending (irq_pending),
        .irq_req     (irq_req),
        .irq_level   (irq_level),
        .irq_chan    (irq_chan),
        .irq_vector  (irq_vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] lvl_of(input logic [7:0] p, input int ch);
        return {p[2*(ch/2)+1], p[2*(ch/2)], ch[0]};
    endfunction

    task automatic check_all();
        logic [3:0] best;
        int         bch;
        logic       exp_req;
        logic [7:0] exp_rd;
        best = 4'd8;
        bch  = 0;
        for (int i = 0; i < 8; i++) begin
            if (m_pend[i] && irq_en[i] && {1'b0, lvl_of(m_prio, i)} < best) begin
                best = {1'b0, lvl_of(m_prio, i)};
                bch  = i;
            end
        end
        exp_req = (best != 4'd8) && (best[2:0] < cur_level);
        chk("R4", {31'd0, irq_pending[0]}, {31'd0, m_pend[0]});
        chk("R5", {24'd0, irq_pending[7:1], 1'b0}, {24'd0, m_pend[7:1], 1'b0});
        chk("R8", {31'd0, irq_req}, {31'd0, exp_req});
        if (exp_req) begin
            chk("R3", {29'd0, irq_level}, {29'd0, best[2:0]});
            chk("R7", {29'd0, irq_chan}, bch);
            if (vhi_known) chk("R9", {24'd0, irq_vector}, {24'd0, m_vhi, 3'(bch), 1'b0});
        end
        case (reg_addr)
            2'd0: chk("R1", {24'd0, reg_rdata}, {24'd0, m_prio});
            2'd1: begin
                if (vhi_known) chk("R2", {24'd0, reg_rdata}, {24'd0, m_vhi, m_vlo});
                else           chk("R2", {28'd0, reg_rdata[3:0]}, {28'd0, m_vlo});
            end
            default: begin
                exp_rd = 8'd0;
                chk("R2", {24'd0, reg_rdata}, {24'd0, exp_rd});
            end
        endcase
    endtask

    task automatic step();
        logic [7:0] src;
        logic [7:0] rise;
        @(posedge clk);
        src  = {irq_pin[7:1], m_vlo[1] ? irq_pin[0] : wdog_eoc};
        rise = src & ~m_prev;
        if (irq_ack) m_pend[ack_chan] = 1'b0;
        m_pend = m_pend | rise;
        m_prev = src;
        if (reg_wr && reg_addr == 2'd0) m_prio = reg_wdata;
        if (reg_wr && reg_addr == 2'd1) begin
            m_vhi = reg_wdata[7:4];
            m_vlo = reg_wdata[3:0];
            vhi_known = 1'b1;
        end
        #1;
        check_all();
        if (irq_ack) chk("R6", {31'd0, irq_pending[ack_chan]}, {31'd0, m_pend[ack_chan]});
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_prio = 8'hFF; m_vlo = 4'b0110; m_prev = 8'hFF; m_pend = 8'h00; m_vhi = 4'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // Reset state
        reg_addr = 2'd0; #1; check_all();
        reg_addr = 2'd1; #1; check_all();
        reg_addr = 2'd2; #1; check_all();
        // Register setup: vector 0xA6 (channel 0 from pin), D=11 C=10 B=01 A=00
        wr_reg(2'd1, 8'hA6);
        wr_reg(2'd0, 8'hE4);
        wr_reg(2'd3, 8'h55);
        irq_en = 8'hFF; cur_level = 3'd7;
        // R3/R7: D1 (level 7) and B0 (level 2) pending, B0 wins
        irq_pin = 8'h84; step(); step();
        // R8 boundary: current level equal to winner blocks request
        cur_level = 3'd2; step();
        cur_level = 3'd3; step();
        // R6: acknowledge B0, D1 remains
        irq_ack = 1'b1; ack_chan = 3'd2; step(); irq_ack = 1'b0;
        cur_level = 3'd0; step();
        irq_pin = 8'h00; step();
        irq_ack = 1'b1; ack_chan = 3'd7; step(); irq_ack = 1'b0;
        // R7 tie: all pairs 00, B0 and C0 both level 0, lower index wins
        wr_reg(2'd0, 8'h00);
        cur_level = 3'd7;
        irq_pin = 8'h14; step(); step();
        // R7 disabled channel does not win
        irq_en = 8'hFB; step();
        irq_en = 8'hFF;
        irq_ack = 1'b1; ack_chan = 3'd2; step();
        ack_chan = 3'd4; step(); irq_ack = 1'b0;
        irq_pin = 8'h00; step();
        // R4: pin selected, watchdog pulse ignored
        wdog_eoc = 1'b1; step(); wdog_eoc = 1'b0; step();
        // R4: watchdog selected, pin pulse ignored, then watchdog counts
        wr_reg(2'd1, 8'h34);
        irq_pin = 8'h01; step(); irq_pin = 8'h00; step();
        wdog_eoc = 1'b1; step(); wdog_eoc = 1'b0; step();
        // R6: ack and new edge in the same cycle keep the bit set
        wr_reg(2'd1, 8'h36);
        irq_ack = 1'b1; ack_chan = 3'd0; irq_pin = 8'h01; step();
        irq_ack = 1'b0; step();
        irq_pin = 8'h00; step();
        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom();
            irq_pin   = irq_pin ^ (8'($urandom()) & 8'($urandom()) & 8'($urandom()));
            wdog_eoc  = (r[3:0] == 4'd0);
            irq_en    = (r[4]) ? 8'hFF : 8'($urandom());
            cur_level = r[7:5];
            irq_ack   = (r[9:8] == 2'd0);
            ack_chan  = r[12:10];
            reg_wr    = (r[16:13] == 4'd0);
            reg_addr  = r[18:17];
            reg_wdata = 8'($urandom());
            step();
        end
        reg_wr = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule